// File: doc/BRIEF.md
# MOESI Snooping Coherence Controller

This block keeps the coherence state of every line in one small direct-mapped cache. The cache sits on a shared snooping bus that carries one transaction at a time. The processor presents one access at a time: a data read, an instruction fetch or a write. The controller answers a hit at once. For anything else it chooses one bus request: a shared read, a clean read, an upgrade, or a write-back of a dirty victim. When the bus grants that request, the controller fills or promotes the line. Each bus transaction is atomic. In the grant cycle every other controller sees the request as a snoop, and each one updates its own copy at the same clock edge as the requester.

The protocol has an owned state. A dirty line can therefore be shared without first going to memory. On a snooped read, the owner drives a supply flag, which tells the bus that memory must stay silent. Any cache that holds the line drives a shared flag. The requester uses the OR of these flags to choose between exclusive and shared when it fills a line.

Top module: `moesi_snoop_ctrl`

## Requirements
- R1: After reset every line is invalid. `cpuState` reads 0 for any address, and `busReq` and `cpuDone` are low.
- R2: `cpuState` reports the line state as four bits: bit 3 dirty, bit 2 readable, bit 1 writable, bit 0 valid. This gives invalid=0x0, shared=0x5, exclusive=0x7, owned=0xD and modified=0xF. It reads 0x0 when the tag does not match.
- R3: A data read miss requests a shared read (`busCmd`=1) with the full line address. On grant, the line fills as exclusive when `busShared` is low and as shared when it is high. The access then completes as a hit on the next cycle.
- R4: An instruction-fetch miss requests a clean read (`busCmd`=2). It uses the same fill rule as R3.
- R5: A read or fetch that hits any valid state raises `cpuDone` in the same cycle, makes no bus request and leaves the state unchanged.
- R6: A write that hits exclusive or modified raises `cpuDone` in the same cycle with no bus request. The line becomes modified at that clock edge.
- R7: A write that hits shared or owned requests an upgrade (`busCmd`=3). In the grant cycle it raises `cpuDone`, and the line becomes modified. A write miss first fetches the line as in R3 and then follows R6 or R7.
- R8: A snooped shared or clean read that hits a valid line raises `snpShared`. Modified becomes owned and exclusive becomes shared; owned and shared stay as they are. `snpSupply` is high exactly when the hit line is dirty.
- R9: A snooped upgrade that hits a valid line raises `snpShared` and keeps `snpSupply` low. The line becomes invalid (0x0).
- R10: A snoop whose tag misses, that hits an invalid line, or that carries a write-back (`busCmd`=4) raises neither flag and changes no state.
- R11: On a miss whose victim is owned or modified, the controller first requests a write-back (`busCmd`=4) carrying the victim's own line address. The victim becomes invalid on grant, and the read request follows. A clean victim is dropped with no write-back.
- R12: A write that hits exclusive or modified waits while a snoop to the same index is on the bus. It raises no `cpuDone` in that cycle and is decided again from the new state on the next cycle.
- R13: After every bus transaction, among all caches at most one copy of a line is exclusive, modified or owned. No exclusive or modified copy exists alongside any other valid copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Processor access request, held until `cpuDone` |
| cpuWrite | input | 1 | Access is a write |
| cpuFetch | input | 1 | Access is an instruction fetch (ignored for writes) |
| cpuAddr | input | ADDR_W | Line address of the access |
| cpuDone | output | 1 | Access completes at this clock edge |
| cpuState | output | 4 | State of the line at `cpuAddr` (0 on tag miss) |
| busReq | output | 1 | Bus request pending |
| busCmd | output | 3 | Requested command: 1 shared read, 2 clean read, 3 upgrade, 4 write-back |
| busAddr | output | ADDR_W | Line address of the request |
| busGrant | input | 1 | Request is carried out at this clock edge |
| busShared | input | 1 | Some other cache holds the requested line |
| snpValid | input | 1 | Another cache's transaction is on the bus |
| snpCmd | input | 3 | Command of the snooped transaction |
| snpAddr | input | ADDR_W | Line address of the snooped transaction |
| snpShared | output | 1 | This cache holds the snooped line |
| snpSupply | output | 1 | This cache supplies the data; memory stays silent |

## Verification
Bus requests, `cpuDone`, `cpuState` and the two snoop flags are combinational, so each is due in the cycle of its stimulus. The bench samples them a fraction of a nanosecond after the falling edge. State changes from a grant or a snoop land at the next rising edge, so the bench reads them in the following cycle. Completing a miss takes one bus transaction for a fill and one more for a write-back or an upgrade. The bench counts grants per access against a reference model of the protocol and checks the state of every cache after each access.

// File: rtl/moesi_pkg.sv
package moesi_pkg;

  typedef struct packed {
    logic dirty;
    logic readable;
    logic writable;
    logic valid;
  } lineState_t;

  localparam lineState_t ST_I = lineState_t'(4'h0);
  localparam lineState_t ST_S = lineState_t'(4'h5);
  localparam lineState_t ST_E = lineState_t'(4'h7);
  localparam lineState_t ST_O = lineState_t'(4'hD);
  localparam lineState_t ST_M = lineState_t'(4'hF);

  typedef enum logic [2:0] {
    CMD_NONE      = 3'd0,
    CMD_RD_SHARED = 3'd1,
    CMD_RD_CLEAN  = 3'd2,
    CMD_UPGRADE   = 3'd3,
    CMD_WRBACK    = 3'd4
  } busCmd_t;

  // strobes from the decision logic to the line store
  typedef struct packed {
    logic       fillEn;
    lineState_t fillState;
    logic       setModified;
    logic       dropLine;
    logic       snoopEn;
    lineState_t snoopState;
  } ctrlStrobes_t;

endpackage

// File: rtl/moesi_line_store.sv
module moesi_line_store
  import moesi_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int INDEX_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [ADDR_W-1:0] snpAddr,
  input  logic              snpValid,
  input  busCmd_t           snpCmd,
  input  ctrlStrobes_t      str,
  output lineState_t        curState,
  output logic [ADDR_W-INDEX_W-1:0] curTag,
  output logic              cpuHit,
  output lineState_t        cpuState,
  output lineState_t        snpState
);
  localparam int LINES = 1 << INDEX_W;
  localparam int TAG_W = ADDR_W - INDEX_W;

  lineState_t       stateArr [LINES];
  logic [TAG_W-1:0] tagArr   [LINES];

  logic [INDEX_W-1:0] cpuIdx, snpIdx;
  logic [TAG_W-1:0]   cpuTag, snpTag;

  assign cpuIdx = cpuAddr[INDEX_W-1:0];
  assign cpuTag = cpuAddr[ADDR_W-1:INDEX_W];
  assign snpIdx = snpAddr[INDEX_W-1:0];
  assign snpTag = snpAddr[ADDR_W-1:INDEX_W];

  assign curState = stateArr[cpuIdx];
  assign curTag   = tagArr[cpuIdx];
  assign cpuHit   = curState.valid && (curTag == cpuTag);
  assign cpuState = cpuHit ? curState : ST_I;
  assign snpState = (stateArr[snpIdx].valid && tagArr[snpIdx] == snpTag)
                    ? stateArr[snpIdx] : ST_I;

  // snoop first, local update last; the control never lets both hit one index
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        stateArr[i] <= ST_I;
        tagArr[i]   <= '0;
      end
    end else begin
      if (str.snoopEn) stateArr[snpIdx] <= str.snoopState;
      if (str.dropLine) stateArr[cpuIdx] <= ST_I;
      if (str.fillEn) begin
        stateArr[cpuIdx] <= str.fillState;
        tagArr[cpuIdx]   <= cpuTag;
      end
      if (str.setModified) stateArr[cpuIdx] <= ST_M;
    end
  end

  assert_snoop_upgrade_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (snpValid && snpCmd == CMD_UPGRADE && snpState.valid) |=> (stateArr[$past(snpIdx)] == ST_I));

  assert_snoop_read_drops_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (snpValid && (snpCmd == CMD_RD_SHARED || snpCmd == CMD_RD_CLEAN) && snpState.valid)
      |=> !stateArr[$past(snpIdx)].writable);

  assert_modify_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(str.setModified) |-> (stateArr[$past(cpuIdx)] == ST_M));

endmodule

// File: rtl/moesi_ctrl.sv
module moesi_ctrl
  import moesi_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int INDEX_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpuReq,
  input  logic              cpuWrite,
  input  logic              cpuFetch,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  lineState_t        curState,
  input  logic [ADDR_W-INDEX_W-1:0] curTag,
  input  logic              cpuHit,
  input  logic              busGrant,
  input  logic              busShared,
  input  logic              snpValid,
  input  busCmd_t           snpCmd,
  input  logic [ADDR_W-1:0] snpAddr,
  input  lineState_t        snpState,
  output logic              cpuDone,
  output logic              busReq,
  output busCmd_t           busCmd,
  output logic [ADDR_W-1:0] busAddr,
  output logic              snpShared,
  output logic              snpSupply,
  output ctrlStrobes_t      str
);
  logic [INDEX_W-1:0] cpuIdx;
  logic snoopSameIdx, snpIsRead, snpHit;

  assign cpuIdx       = cpuAddr[INDEX_W-1:0];
  assign snoopSameIdx = snpValid && (snpAddr[INDEX_W-1:0] == cpuIdx);
  assign snpIsRead    = (snpCmd == CMD_RD_SHARED) || (snpCmd == CMD_RD_CLEAN);
  assign snpHit       = snpValid && snpState.valid;
  assign snpShared    = snpHit && (snpIsRead || snpCmd == CMD_UPGRADE);
  assign snpSupply    = snpHit && snpIsRead && snpState.dirty;

  always_comb begin
    str     = '0;
    cpuDone = 1'b0;
    busReq  = 1'b0;
    busCmd  = CMD_NONE;
    busAddr = cpuAddr;
    if (cpuReq) begin
      if (cpuHit) begin
        if (!cpuWrite) begin
          cpuDone = 1'b1;
        end else if (curState.writable) begin
          if (!snoopSameIdx) begin
            cpuDone         = 1'b1;
            str.setModified = 1'b1;
          end
        end else begin
          busReq = 1'b1;
          busCmd = CMD_UPGRADE;
          if (busGrant) begin
            cpuDone         = 1'b1;
            str.setModified = 1'b1;
          end
        end
      end else if (curState.valid && curState.dirty) begin
        busReq  = 1'b1;
        busCmd  = CMD_WRBACK;
        busAddr = {curTag, cpuIdx};
        if (busGrant) str.dropLine = 1'b1;
      end else begin
        busReq = 1'b1;
        busCmd = (cpuFetch && !cpuWrite) ? CMD_RD_CLEAN : CMD_RD_SHARED;
        if (busGrant) begin
          str.fillEn    = 1'b1;
          str.fillState = busShared ? ST_S : ST_E;
        end
      end
    end
    if (snpHit && snpIsRead) begin
      str.snoopEn    = 1'b1;
      str.snoopState = snpState.dirty ? ST_O : ST_S;
    end else if (snpHit && snpCmd == CMD_UPGRADE) begin
      str.snoopEn    = 1'b1;
      str.snoopState = ST_I;
    end
  end

  assert_supply_needs_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    snpSupply |-> snpShared);

  assert_wb_only_dirty_miss_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busReq && busCmd == CMD_WRBACK) |-> (!cpuHit && curState.dirty));

  assert_read_only_on_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busReq && (busCmd == CMD_RD_SHARED || busCmd == CMD_RD_CLEAN)) |-> !cpuHit);

endmodule

// File: rtl/moesi_snoop_ctrl.sv
module moesi_snoop_ctrl
  import moesi_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int INDEX_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpuReq,
  input  logic              cpuWrite,
  input  logic              cpuFetch,
  input  logic [ADDR_W-1:0] cpuAddr,
  output logic              cpuDone,
  output logic [3:0]        cpuState,
  output logic              busReq,
  output logic [2:0]        busCmd,
  output logic [ADDR_W-1:0] busAddr,
  input  logic              busGrant,
  input  logic              busShared,
  input  logic              snpValid,
  input  logic [2:0]        snpCmd,
  input  logic [ADDR_W-1:0] snpAddr,
  output logic              snpShared,
  output logic              snpSupply
);
  busCmd_t      snpCmdT, busCmdT;
  ctrlStrobes_t str;
  lineState_t   curState, lookState, snpState;
  logic [ADDR_W-INDEX_W-1:0] curTag;
  logic         cpuHit;

  assign snpCmdT  = busCmd_t'(snpCmd);
  assign busCmd   = busCmdT;
  assign cpuState = lookState;

  moesi_ctrl #(.ADDR_W(ADDR_W), .INDEX_W(INDEX_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .cpuReq(cpuReq), .cpuWrite(cpuWrite), .cpuFetch(cpuFetch), .cpuAddr(cpuAddr),
    .curState(curState), .curTag(curTag), .cpuHit(cpuHit),
    .busGrant(busGrant), .busShared(busShared),
    .snpValid(snpValid), .snpCmd(snpCmdT), .snpAddr(snpAddr), .snpState(snpState),
    .cpuDone(cpuDone), .busReq(busReq), .busCmd(busCmdT), .busAddr(busAddr),
    .snpShared(snpShared), .snpSupply(snpSupply), .str(str)
  );

  moesi_line_store #(.ADDR_W(ADDR_W), .INDEX_W(INDEX_W)) store_i (
    .clk(clk), .rst_n(rst_n),
    .cpuAddr(cpuAddr), .snpAddr(snpAddr), .snpValid(snpValid), .snpCmd(snpCmdT),
    .str(str), .curState(curState), .curTag(curTag), .cpuHit(cpuHit),
    .cpuState(lookState), .snpState(snpState)
  );

endmodule

// File: tb/moesi_snoop_ctrl_tb_top.sv
`timescale 1ns/100ps
module moesi_snoop_ctrl_tb_top;
  localparam int AW = 6;
  localparam int IW = 2;
  localparam int NC = 3;
  localparam logic [3:0] SI = 4'h0, SS = 4'h5, SE = 4'h7, SO = 4'hD, SM = 4'hF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          cReq [NC];
  logic          cWrite [NC];
  logic          cFetch [NC];
  logic [AW-1:0] cAddr [NC];
  logic          cDone [NC];
  logic [3:0]    cState [NC];
  logic          cBusReq [NC];
  logic [2:0]    cBusCmd [NC];
  logic [AW-1:0] cBusAddr [NC];
  logic          cGrant [NC];
  logic          cShIn [NC];
  logic          cSnpValid [NC];
  logic          snpShared [NC];
  logic          snpSupply [NC];
  logic [2:0]    snpCmdBus;
  logic [AW-1:0] snpAddrBus;
  logic          anyGrant, memRespond;
  int            winner;

  for (genvar g = 0; g < NC; g++) begin : cacheGen
    moesi_snoop_ctrl #(.ADDR_W(AW), .INDEX_W(IW)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .cpuReq(cReq[g]), .cpuWrite(cWrite[g]), .cpuFetch(cFetch[g]), .cpuAddr(cAddr[g]),
      .cpuDone(cDone[g]), .cpuState(cState[g]),
      .busReq(cBusReq[g]), .busCmd(cBusCmd[g]), .busAddr(cBusAddr[g]),
      .busGrant(cGrant[g]), .busShared(cShIn[g]),
      .snpValid(cSnpValid[g]), .snpCmd(snpCmdBus), .snpAddr(snpAddrBus),
      .snpShared(snpShared[g]), .snpSupply(snpSupply[g])
    );
  end

  // fixed-priority bus, lowest index wins
  always_comb begin
    winner = NC;
    for (int k = NC - 1; k >= 0; k--) if (cBusReq[k]) winner = k;
    anyGrant   = (winner != NC);
    snpCmdBus  = 3'd0;
    snpAddrBus = '0;
    for (int k = 0; k < NC; k++) begin
      cGrant[k]    = (k == winner);
      cSnpValid[k] = anyGrant && (k != winner);
      if (k == winner) begin
        snpCmdBus  = cBusCmd[k];
        snpAddrBus = cBusAddr[k];
      end
    end
  end

  always_comb begin
    memRespond = 1'b1;
    for (int k = 0; k < NC; k++) begin
      cShIn[k] = 1'b0;
      for (int j = 0; j < NC; j++) if (j != k && snpShared[j]) cShIn[k] = 1'b1;
      if (snpSupply[k]) memRespond = 1'b0;
    end
  end

  int txCount = 0;
  always @(posedge clk) if (rst_n && anyGrant) txCount++;

  int nChecks = 0;
  int nFails = 0;
  logic [3:0] refSt [NC];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: run hung actual=0 expected=1");
    finishRun();
  end

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int k = 0; k < NC; k++) begin
      cReq[k] = 0; cWrite[k] = 0; cFetch[k] = 0; cAddr[k] = '0;
      refSt[k] = SI;
    end
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic setReq(input int k, input bit wr, input bit fe, input logic [AW-1:0] a);
    cReq[k] = 1'b1; cWrite[k] = wr; cFetch[k] = fe; cAddr[k] = a;
  endtask

  task automatic waitDone(input int k);
    bit d;
    for (int n = 0; n < 10; n++) begin
      #0.4;
      d = cDone[k];
      @(negedge clk);
      if (d) begin
        cReq[k] = 1'b0;
        return;
      end
    end
    cReq[k] = 1'b0;
    check(1'b0, "R3", "access never completed", 0, 1);
  endtask

  // reference protocol model for one line
  task automatic refOp(input int k, input int op, output int nTx);
    bit others;
    nTx = 0;
    if (refSt[k] == SI) begin
      nTx++;
      others = 0;
      for (int j = 0; j < NC; j++) if (j != k && refSt[j] != SI) others = 1;
      for (int j = 0; j < NC; j++)
        if (j != k) begin
          if (refSt[j] == SM) refSt[j] = SO;
          else if (refSt[j] == SE) refSt[j] = SS;
        end
      refSt[k] = others ? SS : SE;
    end
    if (op == 2) begin
      if (refSt[k] == SS || refSt[k] == SO) begin
        nTx++;
        for (int j = 0; j < NC; j++) if (j != k) refSt[j] = SI;
      end
      refSt[k] = SM;
    end
  endtask

  task automatic checkInvariant();
    int own, valid;
    bit excl;
    own = 0; valid = 0; excl = 0;
    for (int j = 0; j < NC; j++) begin
      if (cState[j] == SM || cState[j] == SE || cState[j] == SO) own++;
      if (cState[j] != SI) valid++;
      if (cState[j] == SM || cState[j] == SE) excl = 1;
    end
    check(own <= 1 && !(excl && valid > 1), "R13", "coherence invariant (owners)", own, 1);
  endtask

  initial begin
    logic [AW-1:0] x, y, z;
    int t0, nTx, op, k, kind;
    for (int k2 = 0; k2 < NC; k2++) begin
      cReq[k2] = 0; cWrite[k2] = 0; cFetch[k2] = 0; cAddr[k2] = '0;
    end
    doReset();

    // R1: reset state
    #0.4;
    for (int j = 0; j < NC; j++) begin
      check(cState[j] == SI, "R1", "state after reset", cState[j], SI);
      check(!cBusReq[j] && !cDone[j], "R1", "idle after reset", cBusReq[j], 0);
    end
    @(negedge clk);

    // directed sequence on one index
    x = 6'h05; y = 6'h15; z = 6'h25;
    for (int j = 0; j < NC; j++) cAddr[j] = x;
    setReq(0, 1, 0, x); waitDone(0);
    #0.4 check(cState[0] == SM, "R2", "write miss ends modified", cState[0], SM);
    @(negedge clk);

    setReq(1, 0, 0, x);
    #0.4;
    check(cBusCmd[1] == 3'd1 && cBusAddr[1] == x, "R3", "shared read request", cBusCmd[1], 1);
    check(snpSupply[0] && snpShared[0] && !memRespond, "R8", "modified owner supplies", snpSupply[0], 1);
    waitDone(1);
    #0.4;
    check(cState[0] == SO, "R2", "modified snooped to owned", cState[0], SO);
    check(cState[1] == SS, "R3", "fill shared when held", cState[1], SS);
    @(negedge clk);

    setReq(2, 0, 1, x);
    #0.4;
    check(cBusCmd[2] == 3'd2, "R4", "fetch uses clean read", cBusCmd[2], 2);
    check(snpSupply[0] && !snpSupply[1] && snpShared[1], "R8", "owned supplies, shared only flags",
          snpSupply[0], 1);
    waitDone(2);
    #0.4;
    check(cState[0] == SO && cState[2] == SS, "R4", "fetch fill shared, owner kept", cState[2], SS);
    @(negedge clk);

    setReq(2, 0, 0, x);
    #0.4;
    check(cDone[2] && !cBusReq[2], "R5", "read hit completes without bus", cDone[2], 1);
    waitDone(2);

    setReq(1, 0, 0, y);
    #0.4;
    check(cBusCmd[1] == 3'd1 && cBusAddr[1] == y, "R11", "clean victim dropped silently", cBusCmd[1], 1);
    check(!snpShared[0] && !snpShared[2], "R10", "tag-miss snoop raises nothing", snpShared[0], 0);
    waitDone(1);
    #0.4;
    check(cState[1] == SE, "R3", "fill exclusive when unheld", cState[1], SE);
    check(cState[0] == SO, "R10", "tag-miss snoop keeps state", cState[0], SO);
    @(negedge clk);

    setReq(1, 1, 0, y);
    #0.4;
    check(cDone[1] && !cBusReq[1], "R6", "write to exclusive is silent", cDone[1], 1);
    waitDone(1);
    #0.4 check(cState[1] == SM, "R6", "exclusive write becomes modified", cState[1], SM);
    @(negedge clk);

    setReq(1, 0, 0, x);
    #0.4;
    check(cBusCmd[1] == 3'd4 && cBusAddr[1] == y, "R11", "dirty victim written back", cBusAddr[1], y);
    check(!snpShared[0] && !snpSupply[0], "R10", "write-back snoop ignored", snpShared[0], 0);
    waitDone(1);
    #0.4 check(cState[1] == SS, "R11", "read follows write-back", cState[1], SS);
    @(negedge clk);

    setReq(0, 0, 0, z);
    #0.4;
    check(cBusCmd[0] == 3'd4 && cBusAddr[0] == x, "R11", "owned victim written back", cBusAddr[0], x);
    check(!snpShared[1] && !snpShared[2], "R10", "write-back snoop on same line ignored",
          snpShared[1], 0);
    waitDone(0);
    cAddr[0] = x;
    #0.4;
    check(cState[1] == SS && cState[2] == SS, "R10", "sharers kept through write-back", cState[1], SS);
    check(cState[0] == SI, "R11", "evicted line invalid", cState[0], SI);
    @(negedge clk);

    // R12 collision: silent write vs snoop on same index
    doReset();
    for (int j = 0; j < NC; j++) cAddr[j] = x;
    setReq(0, 0, 0, x); waitDone(0);
    setReq(0, 1, 0, x);
    setReq(1, 0, 0, x);
    #0.4;
    check(!cDone[0], "R12", "silent write waits for snoop", cDone[0], 0);
    check(cGrant[1] && cBusCmd[1] == 3'd1, "R12", "other read proceeds", cBusCmd[1], 1);
    @(negedge clk);
    #0.4;
    check(cBusCmd[0] == 3'd3 && cBusReq[0], "R7", "write to shared requests upgrade", cBusCmd[0], 3);
    check(snpShared[1] && !snpSupply[1], "R9", "upgrade snoop flags shared only", snpSupply[1], 0);
    check(cDone[0] && cDone[1], "R7", "upgrade and read complete", cDone[0], 1);
    @(negedge clk);
    cReq[0] = 0; cReq[1] = 0;
    #0.4;
    check(cState[0] == SM, "R7", "upgrade ends modified", cState[0], SM);
    check(cState[1] == SI, "R9", "upgrade invalidates peer", cState[1], SI);
    @(negedge clk);

    // near-exhaustive sweep: every 3-access sequence of (cache, kind)
    for (int s = 0; s < 729; s++) begin
      doReset();
      x = AW'(s % 64);
      for (int j = 0; j < NC; j++) cAddr[j] = x;
      for (int i = 0; i < 3; i++) begin
        op = (i == 0) ? (s % 9) : (i == 1) ? ((s / 9) % 9) : (s / 81);
        k = op % NC;
        kind = op / NC;
        refOp(k, kind, nTx);
        t0 = txCount;
        setReq(k, kind == 2, kind == 1, x);
        waitDone(k);
        #0.4;
        check(txCount - t0 == nTx,
              (kind == 2) ? "R7" : (kind == 1) ? "R4" : "R3",
              "bus transactions per access", txCount - t0, nTx);
        for (int j = 0; j < NC; j++)
          check(cState[j] == refSt[j],
                (j == k) ? ((kind == 2) ? "R7" : "R3") : ((kind == 2) ? "R9" : "R8"),
                "line state after access", cState[j], refSt[j]);
        checkInvariant();
        @(negedge clk);
      end
    end
    finishRun();
  end

endmodule